// File: doc/BRIEF.md
# Double-Buffered Video Memory Refresh Scheduler

This block generates raster timing for a 1024x1024, 8-bit-per-pixel display. It also tells a dual-ported video memory when to load a new scan-line group into the memory's internal shift registers. It runs on a pixel-group clock, in which one cycle is one shift of the serial port: each shift delivers 16 pixels, so an active line lasts 64 cycles. Front porch, sync width and back porch are parameters, both horizontally and vertically. Blank, horizontal sync and vertical sync come straight from the position counters. A shift enable is high only inside the active picture, so the serial port consumes no pixels during blanking.

The video memory holds two whole frame buffers. Each buffer is built from four device rows that share their address lines, and two upper address bits pick the active row. One transfer cycle fills the shift registers with four scan lines, which is 4096 pixels. The scheduler therefore issues a transfer in the horizontal blanking just before every fourth line. Each transfer carries the buffer bit, the two row-select bits and the row address.

The drawing side asks for a buffer exchange with a one-cycle request. The request is held until the next start of vertical blanking, and the displayed buffer changes only at that point. A displayed frame therefore never mixes two images. A one-cycle acknowledge marks the first pixel shown from the new buffer.

Top module: `vram_refresh_sched`

## Requirements
- R1: Once reset is released, the position is the first active pixel of line 0. In that state the displayed buffer is 0, blank is low, shiftEn is high, and xferReq and swapAck are low.
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clock cycles, where H_ACTIVE = LINE_PIXELS/PIX_PER_SHIFT. hSync is high, active high, for the H_SYNC cycles that begin H_ACTIVE+H_FP cycles after the start of the line.
- R3: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. vSync is high, active high, on lines V_ACTIVE+V_FP through V_ACTIVE+V_FP+V_SYNC-1.
- R4: blank is high whenever the horizontal position is at least H_ACTIVE or the line is at least V_ACTIVE. shiftEn is always the inverse of blank.
- R5: xferReq is a one-cycle pulse at the first blanking cycle (horizontal position H_ACTIVE) of the line just before each line n, where n is a multiple of 4 below V_ACTIVE. The transfer for line 0 goes out on the last line of the previous frame. Every frame therefore carries exactly V_ACTIVE/4 transfers.
- R6: During a transfer pulse, the group index is g = n/4. xferRowSel carries the two most significant bits of g, xferRowAddr carries the remaining low bits of g, and xferBuf equals dispBuf.
- R7: A swapReq pulse in any cycle is remembered. dispBuf toggles at the clock edge that enters the first vertical-blanking cycle (line V_ACTIVE, position 0), and at no other edge.
- R8: A request that arrives after that edge, during vertical blanking, does not take effect until the following frame's blanking start.
- R9: Any number of requests before one blanking start produce exactly one toggle.
- R10: swapAck is a one-cycle pulse on the first active pixel (line 0, position 0) of the first frame shown after a toggle. swapAck is never high in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock, one cycle per shift |
| rstN | input | 1 | Active-low synchronous reset |
| swapReq | input | 1 | One-cycle request to exchange display and drawing buffers |
| swapAck | output | 1 | Pulse on the first pixel shown from a newly selected buffer |
| dispBuf | output | 1 | Buffer currently being displayed |
| xferReq | output | 1 | Shift-register transfer request pulse |
| xferBuf | output | 1 | Buffer addressed by the transfer |
| xferRowSel | output | 2 | Device-row select bits of the transfer |
| xferRowAddr | output | 6 | Row address within the selected device row |
| shiftEn | output | 1 | Serial shift clock enable, high in active video |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the active picture |

## Verification
Several properties are checked on every cycle:
- The horizontal counter stays in range.
- Transfers happen only while blank is high, and each transfer lasts one cycle.
- The displayed buffer changes only at the vertical-blanking start.
- Every accepted swap leaves the acknowledge armed and the pending request cleared.
- The acknowledge lasts a single cycle.

Some behaviours only the bench scenarios can show. These are the exact cycle positions of the sync pulses and transfers, the group-to-row address mapping, and the number of transfers per frame. They also include the fact that a request landing just after the boundary waits a whole frame, and that bunched requests fold into one swap.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  // Strobes issued by the control to the timing datapath
  typedef struct packed {
    logic swap;   // toggle displayed buffer at this edge
    logic xfer;   // transfer request in this cycle
  } ctrlStrobes_t;

  // Position flags reported by the datapath to the control
  typedef struct packed {
    logic xferSlot;  // first blank cycle of a line preceding a group start
    logic frameEnd;  // last cycle before vertical blanking begins
    logic firstPix;  // first active pixel of the frame
  } posStatus_t;

endpackage

// File: rtl/vrs_timing_dp.sv
module vrs_timing_dp
  import vrs_pkg::*;
#(
  parameter int H_ACTIVE       = 64,
  parameter int H_FP           = 2,
  parameter int H_SYNC         = 8,
  parameter int H_BP           = 6,
  parameter int V_ACTIVE       = 1024,
  parameter int V_FP           = 3,
  parameter int V_SYNC         = 6,
  parameter int V_BP           = 29,
  parameter int LINES_PER_XFER = 4,
  parameter int ROW_ADDR_W     = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  output posStatus_t            stat,
  output logic                  dispBuf,
  output logic                  xferBuf,
  output logic [1:0]            xferRowSel,
  output logic [ROW_ADDR_W-1:0] xferRowAddr,
  output logic                  shiftEn,
  output logic                  hSync,
  output logic                  vSync,
  output logic                  blank
);

  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int H_W      = $clog2(H_TOTAL);
  localparam int V_W      = $clog2(V_TOTAL);
  localparam int LX_W     = $clog2(LINES_PER_XFER);
  localparam int GROUP_W  = $clog2(V_ACTIVE / LINES_PER_XFER);
  localparam int HS_START = H_ACTIVE + H_FP;
  localparam int VS_START = V_ACTIVE + V_FP;

  logic [H_W-1:0]     hCnt;
  logic [V_W-1:0]     vCnt;
  logic [V_W-1:0]     nextLine;
  logic [GROUP_W-1:0] grp;
  logic               hLast;
  logic               hAct;
  logic               vAct;
  logic               groupStart;

  assign hLast = (int'(hCnt) == H_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt    <= '0;
      vCnt    <= '0;
      dispBuf <= 1'b0;
    end else begin
      if (hLast) begin
        hCnt <= '0;
        vCnt <= nextLine;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
      if (strb.swap) dispBuf <= ~dispBuf;
    end
  end

  always_comb begin
    nextLine   = (int'(vCnt) == V_TOTAL - 1) ? '0 : vCnt + 1'b1;
    grp        = nextLine[LX_W +: GROUP_W];
    groupStart = (nextLine[LX_W-1:0] == '0) && (int'(nextLine) < V_ACTIVE);
    hAct       = int'(hCnt) < H_ACTIVE;
    vAct       = int'(vCnt) < V_ACTIVE;

    stat.xferSlot = groupStart && (int'(hCnt) == H_ACTIVE);
    stat.frameEnd = hLast && (int'(vCnt) == V_ACTIVE - 1);
    stat.firstPix = (hCnt == '0) && (vCnt == '0);

    blank   = !(hAct && vAct);
    shiftEn = hAct && vAct;
    hSync   = (int'(hCnt) >= HS_START) && (int'(hCnt) < HS_START + H_SYNC);
    vSync   = (int'(vCnt) >= VS_START) && (int'(vCnt) < VS_START + V_SYNC);

    xferBuf     = dispBuf;
    xferRowSel  = grp[GROUP_W-1 -: 2];
    xferRowAddr = grp[ROW_ADDR_W-1:0];
  end

  // R2
  hcount_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(hCnt) < H_TOTAL);

  // R5
  xfer_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |-> blank);

  // R5
  xfer_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> !strb.xfer);

  // R7
  buf_change_at_vblank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dispBuf) |-> (hCnt == '0 && int'(vCnt) == V_ACTIVE));

endmodule

// File: rtl/vrs_ctrl.sv
module vrs_ctrl
  import vrs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         swapReq,
  input  posStatus_t   stat,
  output ctrlStrobes_t strb,
  output logic         swapAck
);

  logic pend;
  logic armed;

  always_comb begin
    strb.xfer = stat.xferSlot;
    strb.swap = stat.frameEnd && (pend || swapReq);
    swapAck   = armed && stat.firstPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend  <= 1'b0;
      armed <= 1'b0;
    end else begin
      pend <= strb.swap ? 1'b0 : (pend | swapReq);
      if (strb.swap)         armed <= 1'b1;
      else if (stat.firstPix) armed <= 1'b0;
    end
  end

  // R9
  swap_clears_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.swap |=> (armed && !pend));

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    swapAck |=> !swapAck);

endmodule

// File: rtl/vram_refresh_sched.sv
module vram_refresh_sched
  import vrs_pkg::*;
#(
  parameter int LINE_PIXELS    = 1024,
  parameter int PIX_PER_SHIFT  = 16,
  parameter int H_FP           = 2,
  parameter int H_SYNC         = 8,
  parameter int H_BP           = 6,
  parameter int V_ACTIVE       = 1024,
  parameter int V_FP           = 3,
  parameter int V_SYNC         = 6,
  parameter int V_BP           = 29,
  parameter int LINES_PER_XFER = 4,
  localparam int H_ACTIVE      = LINE_PIXELS / PIX_PER_SHIFT,
  localparam int ROW_ADDR_W    = $clog2(V_ACTIVE / LINES_PER_XFER) - 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  swapReq,
  output logic                  swapAck,
  output logic                  dispBuf,
  output logic                  xferReq,
  output logic                  xferBuf,
  output logic [1:0]            xferRowSel,
  output logic [ROW_ADDR_W-1:0] xferRowAddr,
  output logic                  shiftEn,
  output logic                  hSync,
  output logic                  vSync,
  output logic                  blank
);

  ctrlStrobes_t strb;
  posStatus_t   stat;

  vrs_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .swapReq (swapReq),
    .stat    (stat),
    .strb    (strb),
    .swapAck (swapAck)
  );

  vrs_timing_dp #(
    .H_ACTIVE       (H_ACTIVE),
    .H_FP           (H_FP),
    .H_SYNC         (H_SYNC),
    .H_BP           (H_BP),
    .V_ACTIVE       (V_ACTIVE),
    .V_FP           (V_FP),
    .V_SYNC         (V_SYNC),
    .V_BP           (V_BP),
    .LINES_PER_XFER (LINES_PER_XFER),
    .ROW_ADDR_W     (ROW_ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stat        (stat),
    .dispBuf     (dispBuf),
    .xferBuf     (xferBuf),
    .xferRowSel  (xferRowSel),
    .xferRowAddr (xferRowAddr),
    .shiftEn     (shiftEn),
    .hSync       (hSync),
    .vSync       (vSync),
    .blank       (blank)
  );

  assign xferReq = strb.xfer;

endmodule

// File: tb/sim_vram_refresh_sched.sv
module sim_vram_refresh_sched;

  localparam int LP  = 64;
  localparam int PPS = 16;
  localparam int HA  = LP / PPS;
  localparam int HFP = 1, HS = 2, HBP = 1;
  localparam int VA  = 32, VFP = 1, VS = 2, VBP = 1;
  localparam int LPX = 4;
  localparam int HT  = HA + HFP + HS + HBP;
  localparam int VT  = VA + VFP + VS + VBP;
  localparam int FRAME = HT * VT;
  localparam int GW  = $clog2(VA / LPX);
  localparam int RAW = GW - 2;

  logic clk = 1'b0;
  logic rstN, swapReq;
  logic swapAck, dispBuf, xferReq, xferBuf, shiftEn, hSync, vSync, blank;
  logic [1:0] xferRowSel;
  logic [RAW-1:0] xferRowAddr;

  always #4 clk = ~clk;

  vram_refresh_sched #(
    .LINE_PIXELS(LP), .PIX_PER_SHIFT(PPS), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .LINES_PER_XFER(LPX)
  ) u0 (
    .clk(clk), .rstN(rstN), .swapReq(swapReq), .swapAck(swapAck),
    .dispBuf(dispBuf), .xferReq(xferReq), .xferBuf(xferBuf),
    .xferRowSel(xferRowSel), .xferRowAddr(xferRowAddr), .shiftEn(shiftEn),
    .hSync(hSync), .vSync(vSync), .blank(blank)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  function automatic bit isReq(input int c);
    // mid frame 0; just after frame 1 vblank start; two more inside frame 2
    return (c == 50) || (c == FRAME + VA * HT + 5) || (c == 600) || (c == 620);
  endfunction

  initial begin
    int h = 0, v = 0;
    bit mBuf = 0, mPend = 0, mArmed = 0;
    int xferCnt = 0, toggles = 0, acks = 0;
    rstN = 1'b0;
    swapReq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "dispBuf", int'(dispBuf), 0);
    chk("R1", "blank", int'(blank), 0);
    chk("R1", "shiftEn", int'(shiftEn), 1);
    chk("R1", "xferReq", int'(xferReq), 0);
    chk("R1", "swapAck", int'(swapAck), 0);

    for (int cyc = 0; cyc < 4 * FRAME; cyc++) begin
      int nl, g;
      bit act, expX, req, fEnd;
      act  = (h < HA) && (v < VA);
      nl   = (v == VT - 1) ? 0 : v + 1;
      expX = (h == HA) && (nl % LPX == 0) && (nl < VA);
      g    = nl / LPX;
      // R2 / R3 / R4 timing
      chk("R2", "hSync", int'(hSync), int'((h >= HA + HFP) && (h < HA + HFP + HS)));
      chk("R3", "vSync", int'(vSync), int'((v >= VA + VFP) && (v < VA + VFP + VS)));
      chk("R4", "blank", int'(blank), int'(!act));
      chk("R4", "shiftEn", int'(shiftEn), int'(act));
      // R5 transfer slot
      chk("R5", "xferReq", int'(xferReq), int'(expX));
      if (expX) begin
        // R6 address fields
        chk("R6", "xferRowSel", int'(xferRowSel), g >> RAW);
        chk("R6", "xferRowAddr", int'(xferRowAddr), g % (1 << RAW));
        chk("R6", "xferBuf", int'(xferBuf), int'(mBuf));
      end
      if (xferReq) xferCnt++;
      // R7 R8 R9 displayed buffer
      chk("R7", "dispBuf", int'(dispBuf), int'(mBuf));
      // R10 acknowledge
      chk("R10", "swapAck", int'(swapAck), int'(mArmed && h == 0 && v == 0));
      if (swapAck) acks++;
      if (cyc % FRAME == FRAME - 1) begin
        chk("R5", "transfers per frame", xferCnt, VA / LPX);
        xferCnt = 0;
      end

      req = isReq(cyc);
      swapReq = req;
      fEnd = (h == HT - 1) && (v == VA - 1);
      if (mArmed && h == 0 && v == 0) mArmed = 0;
      if (fEnd && (mPend || req)) begin
        mBuf = ~mBuf;
        mPend = 0;
        mArmed = 1;
        toggles++;
      end else if (req) begin
        mPend = 1;
      end
      if (h == HT - 1) begin
        h = 0;
        v = nl;
      end else begin
        h++;
      end
      @(negedge clk);
      #1;
    end
    swapReq = 1'b0;
    // R8: the late request in frame 1 lands in frame 2; R9: bunched requests give one toggle
    chk("R9", "toggle count", toggles, 2);
    chk("R8", "final buffer", int'(dispBuf), 0);
    chk("R10", "ack count", acks, 2);
    summary();
  end

endmodule